// File: doc/BRIEF.md
# Ring Command Stream Parser

This block drains a stream of 32-bit command words from a circular region of shared memory. A host writes the words and moves a producer byte offset forward. The parser keeps the consumer byte offset and reads words through a synchronous single-port RAM read interface. It identifies each opcode, gathers the argument words that follow it, and presents the decoded command on a valid/ready handshake.

The host programs the lower and upper ring bounds and an initial consumer offset, then pulses a commit strobe. The parser then checks that configuration before it accepts it. A command that is only partly in the ring is undone: the consumer offset goes back to the command's first word, and the parser waits until the producer offset moves. Opcodes that are known but not implemented are stepped over by their fixed word counts. An undefined opcode stops the parser until the next commit.

Top module: `cmdring_parser`

## Requirements
- R1: After reset, cmd_valid, cfg_ok and halted are 0, cons_off is 0 and no RAM read is issued.
- R2: A commit is accepted (cfg_ok=1) only if the following all hold: cfg_min, cfg_max, cfg_rd_init and prod_off are multiples of 4; cfg_min >= 16; cfg_max <= 65536; cfg_max >= cfg_min + 10240; cfg_rd_init and prod_off both lie in [cfg_min, cfg_max). Otherwise cfg_ok becomes 0.
- R3: Waiting words are (prod_off - cons_off)/4, plus (cfg_max - cfg_min)/4 when prod_off < cons_off. The count is zero, and no command starts, while enable or cfg_ok is low.
- R4: Each word read moves cons_off up by 4. When the result reaches or passes cfg_max, cons_off is reloaded with cfg_min.
- R5: Opcodes 1 and 25 take 4 argument words, opcode 2 takes 5 and opcode 3 takes 6. Each is presented with cmd_op equal to the opcode's low 8 bits and argument i at cmd_args[32*i +: 32], in ring order.
- R6: If fewer words wait than a command needs, cons_off returns to that command's first word and no further read is issued until prod_off changes. The command is then parsed again and presented once.
- R7: Opcode 13 (6 words), opcode 14 (7 words) and opcode 28 (12 words) are consumed with no command presented.
- R8: Any other opcode, including 0 and any value above 255, sets halted. While halted, no read is issued and no command is presented. The next commit clears halted.
- R9: Opcode 19 has 7 header words (id, hot x, hot y, width w, height h, depth, bpp), presented as args 0 to 6. It is followed by ((w+31)>>5)*h mask words and then ((w*bpp+31)>>5)*h image words, all consumed. If the mask exceeds 4096 words or the image exceeds 4096 words, halted is set.
- R10: While cmd_valid is 1 and cmd_ready is 0, cmd_valid, cmd_op and cmd_args hold steady and no RAM read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Device enable; parsing starts only while high |
| cfg_commit | input | 1 | One-cycle strobe: check and load the ring configuration |
| cfg_min | input | 17 | Lower ring bound, byte offset |
| cfg_max | input | 17 | Upper ring bound, byte offset (exclusive) |
| cfg_rd_init | input | 17 | Initial consumer byte offset |
| prod_off | input | 17 | Producer byte offset, kept by the host |
| cfg_ok | output | 1 | Last commit accepted |
| cons_off | output | 17 | Consumer byte offset |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_addr | output | 14 | RAM word address |
| ram_rdata | input | 32 | RAM read data, one cycle after ram_rd_en |
| cmd_valid | output | 1 | Decoded command present |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_op | output | 8 | Opcode |
| cmd_args | output | 224 | Argument words, 32 bits each |
| halted | output | 1 | Parsing stopped on a bad opcode or an oversized cursor |

## Verification
The assertions assume that the host keeps prod_off aligned and inside the committed bounds. They also assume that ring words are not rewritten before the parser has consumed them, and that the configuration inputs are steady while cfg_commit is high. The bench writes words through a producer model that wraps at the same bounds the parser uses. It publishes prod_off only after a whole burst of words is in memory. Every commit it issues either passes all the checks or deliberately breaks exactly one of them.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

  typedef enum logic [1:0] {
    K_DRAW   = 2'd0,
    K_CURSOR = 2'd1,
    K_SKIP   = 2'd2,
    K_BAD    = 2'd3
  } op_kind_e;

  localparam logic [31:0] OPC_UPDATE   = 32'd1;
  localparam logic [31:0] OPC_FILL     = 32'd2;
  localparam logic [31:0] OPC_COPY     = 32'd3;
  localparam logic [31:0] OPC_ROP_FILL = 32'd13;
  localparam logic [31:0] OPC_ROP_COPY = 32'd14;
  localparam logic [31:0] OPC_CURSOR   = 32'd19;
  localparam logic [31:0] OPC_UPDATE_V = 32'd25;
  localparam logic [31:0] OPC_BLEND    = 32'd28;

  function automatic op_kind_e op_kind(input logic [31:0] w);
    case (w)
      OPC_UPDATE, OPC_UPDATE_V, OPC_FILL, OPC_COPY: op_kind = K_DRAW;
      OPC_CURSOR:                                   op_kind = K_CURSOR;
      OPC_ROP_FILL, OPC_ROP_COPY, OPC_BLEND:        op_kind = K_SKIP;
      default:                                      op_kind = K_BAD;
    endcase
  endfunction

  // Words after the opcode; for the cursor this is the header only.
  function automatic logic [31:0] op_words(input logic [31:0] w);
    case (w)
      OPC_UPDATE, OPC_UPDATE_V: op_words = 32'd4;
      OPC_FILL:                 op_words = 32'd5;
      OPC_COPY:                 op_words = 32'd6;
      OPC_ROP_FILL:             op_words = 32'd6;
      OPC_ROP_COPY:             op_words = 32'd7;
      OPC_CURSOR:               op_words = 32'd7;
      OPC_BLEND:                op_words = 32'd12;
      default:                  op_words = 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/cmdring_cfgchk.sv
module cmdring_cfgchk #(
  parameter int OFS_W      = 17,
  parameter int RING_BYTES = 65536,
  parameter int HDR_BYTES  = 16,
  parameter int MIN_SPAN   = 10240
) (
  input  logic [OFS_W-1:0] lo_i,
  input  logic [OFS_W-1:0] hi_i,
  input  logic [OFS_W-1:0] rd_i,
  input  logic [OFS_W-1:0] wr_i,
  output logic             ok_o
);
  logic [31:0] lo, hi, rd, wr;
  logic        aligned, lo_fit, hi_fit, span_fit, rd_fit, wr_fit;

  always_comb begin
    lo       = 32'(lo_i);
    hi       = 32'(hi_i);
    rd       = 32'(rd_i);
    wr       = 32'(wr_i);
    aligned  = ((lo_i | hi_i | rd_i | wr_i) & OFS_W'(3)) == '0;
    lo_fit   = lo >= 32'(HDR_BYTES);
    hi_fit   = hi <= 32'(RING_BYTES);
    span_fit = hi >= lo + 32'(MIN_SPAN);
    rd_fit   = (rd >= lo) && (rd < hi);
    wr_fit   = (wr >= lo) && (wr < hi);
    ok_o     = aligned && lo_fit && hi_fit && span_fit && rd_fit && wr_fit;
  end
endmodule

// File: rtl/cmdring_ptr.sv
module cmdring_ptr #(
  parameter int OFS_W = 17,
  localparam int AVW  = OFS_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic             commit_ok,
  input  logic [OFS_W-1:0] lo_i,
  input  logic [OFS_W-1:0] hi_i,
  input  logic [OFS_W-1:0] rd_init_i,
  input  logic [OFS_W-1:0] wr_i,
  input  logic             enable,
  input  logic             mark,
  input  logic             adv,
  input  logic             restore,
  output logic [OFS_W-1:0] rd_q,
  output logic [OFS_W-1:0] lo_q,
  output logic [OFS_W-1:0] hi_q,
  output logic             ok_q,
  output logic [AVW-1:0]   avail
);
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] rd_nxt;
  logic [OFS_W:0]   inc;
  logic [OFS_W:0]   diff;

  always_comb begin
    inc    = {1'b0, rd_q} + (OFS_W+1)'(4);
    rd_nxt = (inc >= {1'b0, hi_q}) ? lo_q : inc[OFS_W-1:0];
  end

  always_comb begin
    if (!(enable && ok_q))
      diff = '0;
    else if (wr_i >= rd_q)
      diff = {1'b0, wr_i} - {1'b0, rd_q};
    else
      diff = {1'b0, wr_i} + {1'b0, hi_q} - {1'b0, lo_q} - {1'b0, rd_q};
    avail = diff[OFS_W:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q    <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      rd_q    <= '0;
      start_q <= '0;
    end else if (commit) begin
      ok_q <= commit_ok;
      if (commit_ok) begin
        lo_q    <= lo_i;
        hi_q    <= hi_i;
        rd_q    <= rd_init_i;
        start_q <= rd_init_i;
      end
    end else if (restore) begin
      rd_q <= start_q;
    end else begin
      if (mark) start_q <= rd_q;
      if (adv)  rd_q    <= rd_nxt;
    end
  end
endmodule

// File: rtl/cmdring_seq.sv
module cmdring_seq
  import cmdring_pkg::*;
#(
  parameter int DW            = 32,
  parameter int MAX_ARGS      = 7,
  parameter int OFS_W         = 17,
  parameter int CUR_MASK_WORDS = 4096,
  parameter int CUR_IMG_WORDS  = 4096,
  localparam int AVW = OFS_W - 1,
  localparam int IW  = $clog2(MAX_ARGS) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   commit,
  input  logic                   run_ok,
  input  logic [AVW-1:0]         avail,
  input  logic [OFS_W-1:0]       wr_i,
  input  logic [DW-1:0]          rd_data,
  output logic                   rd_en,
  output logic                   mark,
  output logic                   restore,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [7:0]             cmd_op,
  output logic [MAX_ARGS*DW-1:0] cmd_args,
  output logic                   halted
);
  typedef enum logic [2:0] {
    S_IDLE, S_OPW, S_RD, S_RDW, S_CHK, S_EMIT, S_HALT
  } st_e;

  st_e              st_q;
  op_kind_e         kind_q, kind_w;
  logic [31:0]      remain_q, need_w, avail_x;
  logic [IW-1:0]    idx_q;
  logic             cap_q, valid_q, halted_q, stalled_q;
  logic [OFS_W-1:0] snap_q;
  logic [7:0]       op_q;
  logic [DW-1:0]    args_q [MAX_ARGS];
  logic [31:0]      mask_w, img_w, payload_w;
  logic             too_big, launch;

  always_comb begin
    kind_w    = op_kind(rd_data);
    need_w    = op_words(rd_data);
    avail_x   = 32'(avail);
    mask_w    = ((args_q[3] + 32'd31) >> 5) * args_q[4];
    img_w     = ((args_q[3] * args_q[6] + 32'd31) >> 5) * args_q[4];
    payload_w = mask_w + img_w;
    too_big   = (mask_w > 32'(CUR_MASK_WORDS)) || (img_w > 32'(CUR_IMG_WORDS));
    launch    = run_ok && (avail != '0) && (!stalled_q || (wr_i != snap_q));
  end

  always_comb begin
    rd_en   = 1'b0;
    mark    = 1'b0;
    restore = 1'b0;
    case (st_q)
      S_IDLE: if (launch) begin rd_en = 1'b1; mark = 1'b1; end
      S_OPW:  if (kind_w != K_BAD && avail_x < need_w) restore = 1'b1;
      S_RD:   rd_en = 1'b1;
      S_CHK:  if (!too_big && avail_x < payload_w) restore = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      kind_q    <= K_DRAW;
      remain_q  <= '0;
      idx_q     <= '0;
      cap_q     <= 1'b0;
      valid_q   <= 1'b0;
      halted_q  <= 1'b0;
      stalled_q <= 1'b0;
      snap_q    <= '0;
      op_q      <= '0;
      for (int i = 0; i < MAX_ARGS; i++) args_q[i] <= '0;
    end else if (commit) begin
      st_q      <= S_IDLE;
      valid_q   <= 1'b0;
      halted_q  <= 1'b0;
      stalled_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (launch) begin
          for (int i = 0; i < MAX_ARGS; i++) args_q[i] <= '0;
          st_q <= S_OPW;
        end
        S_OPW: begin
          op_q   <= rd_data[7:0];
          kind_q <= kind_w;
          if (kind_w == K_BAD) begin
            halted_q <= 1'b1;
            st_q     <= S_HALT;
          end else if (avail_x < need_w) begin
            stalled_q <= 1'b1;
            snap_q    <= wr_i;
            st_q      <= S_IDLE;
          end else begin
            remain_q <= need_w;
            idx_q    <= '0;
            cap_q    <= (kind_w != K_SKIP);
            st_q     <= S_RD;
          end
        end
        S_RD: st_q <= S_RDW;
        S_RDW: begin
          for (int i = 0; i < MAX_ARGS; i++)
            if (cap_q && idx_q == IW'(i)) args_q[i] <= rd_data;
          idx_q    <= idx_q + 1'b1;
          remain_q <= remain_q - 32'd1;
          if (remain_q == 32'd1) begin
            if (kind_q == K_SKIP) begin
              stalled_q <= 1'b0;
              st_q      <= S_IDLE;
            end else if (kind_q == K_CURSOR && cap_q) begin
              st_q <= S_CHK;
            end else begin
              valid_q <= 1'b1;
              st_q    <= S_EMIT;
            end
          end else begin
            st_q <= S_RD;
          end
        end
        S_CHK: begin
          if (too_big) begin
            halted_q <= 1'b1;
            st_q     <= S_HALT;
          end else if (avail_x < payload_w) begin
            stalled_q <= 1'b1;
            snap_q    <= wr_i;
            st_q      <= S_IDLE;
          end else if (payload_w == 32'd0) begin
            valid_q <= 1'b1;
            st_q    <= S_EMIT;
          end else begin
            remain_q <= payload_w;
            cap_q    <= 1'b0;
            st_q     <= S_RD;
          end
        end
        S_EMIT: if (cmd_ready) begin
          valid_q   <= 1'b0;
          stalled_q <= 1'b0;
          st_q      <= S_IDLE;
        end
        default: st_q <= S_HALT;
      endcase
    end
  end

  for (genvar g = 0; g < MAX_ARGS; g++) begin : g_args
    assign cmd_args[g*DW +: DW] = args_q[g];
  end

  assign cmd_valid = valid_q;
  assign cmd_op    = op_q;
  assign halted    = halted_q;
endmodule

// File: rtl/cmdring_parser.sv
module cmdring_parser #(
  parameter int RING_BYTES     = 65536,
  parameter int HDR_BYTES      = 16,
  parameter int MIN_SPAN       = 10240,
  parameter int MAX_ARGS       = 7,
  parameter int CUR_MASK_WORDS = 4096,
  parameter int CUR_IMG_WORDS  = 4096,
  localparam int DW    = 32,
  localparam int OFS_W = $clog2(RING_BYTES) + 1,
  localparam int AW    = $clog2(RING_BYTES) - 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enable,
  input  logic                   cfg_commit,
  input  logic [OFS_W-1:0]       cfg_min,
  input  logic [OFS_W-1:0]       cfg_max,
  input  logic [OFS_W-1:0]       cfg_rd_init,
  input  logic [OFS_W-1:0]       prod_off,
  output logic                   cfg_ok,
  output logic [OFS_W-1:0]       cons_off,
  output logic                   ram_rd_en,
  output logic [AW-1:0]          ram_addr,
  input  logic [DW-1:0]          ram_rdata,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [7:0]             cmd_op,
  output logic [MAX_ARGS*DW-1:0] cmd_args,
  output logic                   halted
);
  logic             commit_ok, mark, restore;
  logic [OFS_W-1:0] min_q, max_q;
  logic [OFS_W-2:0] avail;

  cmdring_cfgchk #(
    .OFS_W(OFS_W), .RING_BYTES(RING_BYTES),
    .HDR_BYTES(HDR_BYTES), .MIN_SPAN(MIN_SPAN)
  ) u_cfg (
    .lo_i(cfg_min), .hi_i(cfg_max), .rd_i(cfg_rd_init), .wr_i(prod_off),
    .ok_o(commit_ok)
  );

  cmdring_ptr #(.OFS_W(OFS_W)) u_ptr (
    .clk(clk), .rst(rst), .commit(cfg_commit), .commit_ok(commit_ok),
    .lo_i(cfg_min), .hi_i(cfg_max), .rd_init_i(cfg_rd_init), .wr_i(prod_off),
    .enable(enable), .mark(mark), .adv(ram_rd_en), .restore(restore),
    .rd_q(cons_off), .lo_q(min_q), .hi_q(max_q), .ok_q(cfg_ok), .avail(avail)
  );

  cmdring_seq #(
    .DW(DW), .MAX_ARGS(MAX_ARGS), .OFS_W(OFS_W),
    .CUR_MASK_WORDS(CUR_MASK_WORDS), .CUR_IMG_WORDS(CUR_IMG_WORDS)
  ) u_seq (
    .clk(clk), .rst(rst), .commit(cfg_commit), .run_ok(enable && cfg_ok),
    .avail(avail), .wr_i(prod_off), .rd_data(ram_rdata),
    .rd_en(ram_rd_en), .mark(mark), .restore(restore),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_args(cmd_args), .halted(halted)
  );

  assign ram_addr = cons_off[AW+1:2];
endmodule

// File: rtl/cmdring_chk.sv
module cmdring_chk #(
  parameter int OFS_W = 17,
  parameter int ARGW  = 224
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_commit,
  input logic             cfg_ok,
  input logic [OFS_W-1:0] cons_off,
  input logic [OFS_W-1:0] min_q,
  input logic [OFS_W-1:0] max_q,
  input logic             ram_rd_en,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [7:0]       cmd_op,
  input logic [ARGW-1:0]  cmd_args,
  input logic             halted
);
  AST_PTR_IN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    cfg_ok |-> (cons_off >= min_q) && (cons_off < max_q)); // R4
  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    cfg_ok |-> cons_off[1:0] == 2'b00); // R2
  AST_READ_NEEDS_CFG: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> cfg_ok); // R3
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && !cfg_commit) |=>
      (cmd_valid && $stable(cmd_op) && $stable(cmd_args))); // R10
  AST_NO_READ_PRESENTING: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !ram_rd_en); // R10
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!ram_rd_en && !cmd_valid)); // R8
endmodule

bind cmdring_parser cmdring_chk #(.OFS_W(OFS_W), .ARGW(MAX_ARGS*32)) u_chk (
  .clk(clk), .rst(rst), .cfg_commit(cfg_commit), .cfg_ok(cfg_ok),
  .cons_off(cons_off), .min_q(min_q), .max_q(max_q), .ram_rd_en(ram_rd_en),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_args(cmd_args), .halted(halted)
);

// File: tb/sim_cmdring_parser.sv
`timescale 1ns/1ps
module sim_cmdring_parser;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b1;
  logic         cfg_commit = 1'b0;
  logic [16:0]  cfg_min = '0, cfg_max = '0, cfg_rd_init = '0, prod_off = '0;
  logic         cfg_ok, ram_rd_en, cmd_valid, halted;
  logic         cmd_ready = 1'b1;
  logic [16:0]  cons_off;
  logic [13:0]  ram_addr;
  logic [31:0]  ram_rdata;
  logic [7:0]   cmd_op;
  logic [223:0] cmd_args;

  cmdring_parser u0 (
    .clk(clk), .rst(rst), .enable(enable), .cfg_commit(cfg_commit),
    .cfg_min(cfg_min), .cfg_max(cfg_max), .cfg_rd_init(cfg_rd_init),
    .prod_off(prod_off), .cfg_ok(cfg_ok), .cons_off(cons_off),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_args(cmd_args), .halted(halted)
  );

  always #10 clk = ~clk;

  logic [31:0] mem [0:4095];
  always_ff @(posedge clk) if (ram_rd_en) ram_rdata <= mem[ram_addr[11:0]];

  int rd_count = 0;
  always @(posedge clk) if (!rst && ram_rd_en) rd_count <= rd_count + 1;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  int prod = 0, r_min = 16, r_max = 16384;

  localparam int NV = 6;
  localparam logic [31:0] VEC [0:NV-1][0:7] = '{
    '{32'd1,  32'd4, 32'd10, 32'd20, 32'd30, 32'd40, 32'd0, 32'd0},
    '{32'd2,  32'd5, 32'hFF00FF, 32'd1, 32'd2, 32'd3, 32'd4, 32'd0},
    '{32'd3,  32'd6, 32'd5, 32'd6, 32'd7, 32'd8, 32'd9, 32'd10},
    '{32'd25, 32'd4, 32'd100, 32'd200, 32'd300, 32'd400, 32'd0, 32'd0},
    '{32'd2,  32'd5, 32'hDEADBEEF, 32'd0, 32'd0, 32'd1, 32'd1, 32'd0},
    '{32'd3,  32'd6, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    mem[prod[13:2]] = w;
    prod += 4;
    if (prod >= r_max) prod = r_min;
  endtask

  task automatic publish();
    prod_off = 17'(prod);
  endtask

  task automatic setup(input int lo, input int hi, input int rd, input int wr);
    @(negedge clk);
    cfg_min = 17'(lo); cfg_max = 17'(hi); cfg_rd_init = 17'(rd); prod_off = 17'(wr);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
  endtask

  task automatic good_setup(input int rd);
    r_min = 16; r_max = 16384; prod = rd;
    setup(16, 16384, rd, rd);
  endtask

  task automatic wait_valid(input int lim, output bit got);
    got = 1'b0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (cmd_valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic take();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit got;
    bit ok;
    int start, rc;
    logic [223:0] held;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!cmd_valid && !cfg_ok && !halted, "R1 flags", {cmd_valid, cfg_ok, halted}, 0);
    chk(cons_off == 0 && rd_count == 0, "R1 pointer/reads", cons_off, 0);

    // R2 rejected configurations
    setup(18, 16384, 20, 20);
    chk(!cfg_ok, "R2 misaligned", cfg_ok, 0);
    setup(8, 16384, 16, 16);
    chk(!cfg_ok, "R2 min inside header", cfg_ok, 0);
    setup(16, 65540, 16, 16);
    chk(!cfg_ok, "R2 max too large", cfg_ok, 0);
    setup(16, 10252, 16, 16);
    chk(!cfg_ok, "R2 span too short", cfg_ok, 0);
    setup(16, 10256, 16, 16);
    chk(cfg_ok, "R2 minimum span accepted", cfg_ok, 1);
    good_setup(16);
    chk(cfg_ok && cons_off == 16, "R2 accept", cons_off, 16);

    // R5 table of commands
    for (int v = 0; v < NV; v++) begin
      push(VEC[v][0]);
      for (int j = 0; j < 32'(VEC[v][1]); j++) push(VEC[v][2+j]);
      publish();
      wait_valid(200, got);
      ok = got && (32'(cmd_op) == VEC[v][0]);
      for (int j = 0; j < 32'(VEC[v][1]); j++)
        if (cmd_args[32*j +: 32] != VEC[v][2+j]) ok = 1'b0;
      chk(ok, "R5 decode", {cmd_op, cmd_args[31:0]}, {VEC[v][0][7:0], VEC[v][2]});
      take();
      chk(32'(cons_off) == prod, "R4 advance", cons_off, prod);
    end

    // R3 disabled: nothing starts
    enable = 1'b0;
    start = prod;
    rc = rd_count;
    push(32'd1); push(32'd1); push(32'd2); push(32'd3); push(32'd4);
    publish();
    idle(40);
    chk(!cmd_valid && 32'(cons_off) == start && rd_count == rc, "R3 disabled", rd_count - rc, 0);
    enable = 1'b1;
    wait_valid(200, got);
    chk(got && cmd_op == 8'd1 && cmd_args[127:96] == 32'd4, "R3 enabled", cmd_op, 1);
    take();

    // R4 wrap at max, R3 count across wrap
    good_setup(16376);
    push(32'd2); push(32'hA); push(32'hB); push(32'hC); push(32'hD); push(32'hE);
    publish();
    wait_valid(200, got);
    chk(got && cmd_op == 8'd2 && cmd_args[31:0] == 32'hA && cmd_args[159:128] == 32'hE,
        "R4 wrapped args", cmd_args[159:128], 32'hE);
    take();
    chk(cons_off == 17'd32, "R4 wrap pointer", cons_off, 32);

    // R6 partial command rolled back
    start = prod;
    push(32'd3); push(32'd11); push(32'd12);
    publish();
    idle(60);
    chk(!cmd_valid && 32'(cons_off) == start, "R6 rollback", cons_off, start);
    rc = rd_count;
    idle(30);
    chk(rd_count == rc, "R6 no rereads", rd_count - rc, 0);
    push(32'd13); push(32'd14); push(32'd15); push(32'd16);
    publish();
    wait_valid(200, got);
    chk(got && cmd_op == 8'd3 && cmd_args[31:0] == 32'd11 && cmd_args[191:160] == 32'd16,
        "R6 retry", cmd_args[191:160], 16);
    take();
    idle(20);
    chk(!cmd_valid && 32'(cons_off) == prod, "R6 presented once", cmd_valid, 0);

    // R7 skipped opcodes
    push(32'd28); for (int j = 0; j < 12; j++) push(32'h55);
    push(32'd14); for (int j = 0; j < 7; j++) push(32'h66);
    push(32'd13); for (int j = 0; j < 6; j++) push(32'h77);
    push(32'd1); push(32'd7); push(32'd8); push(32'd9); push(32'd10);
    publish();
    wait_valid(300, got);
    chk(got && cmd_op == 8'd1 && cmd_args[31:0] == 32'd7, "R7 skip", cmd_op, 1);
    take();
    chk(32'(cons_off) == prod, "R7 consumed", cons_off, prod);

    // R9 cursor with payload
    push(32'd19); push(32'd5); push(32'd1); push(32'd2); push(32'd40); push(32'd2);
    push(32'd24); push(32'd1);
    for (int j = 0; j < 8; j++) push(32'h99);
    push(32'd1); push(32'd1); push(32'd2); push(32'd3); push(32'd4);
    publish();
    wait_valid(300, got);
    chk(got && cmd_op == 8'd19 && cmd_args[31:0] == 32'd5 && cmd_args[127:96] == 32'd40
        && cmd_args[223:192] == 32'd1, "R9 cursor header", cmd_args[127:96], 40);
    take();
    wait_valid(200, got);
    chk(got && cmd_op == 8'd1 && cmd_args[31:0] == 32'd1, "R9 payload consumed", cmd_op, 1);
    take();

    // R10 handshake hold
    cmd_ready = 1'b0;
    push(32'd2); push(32'd21); push(32'd22); push(32'd23); push(32'd24); push(32'd25);
    push(32'd1); push(32'd31); push(32'd32); push(32'd33); push(32'd34);
    publish();
    wait_valid(200, got);
    held = cmd_args;
    rc = rd_count;
    idle(12);
    chk(got && cmd_valid && cmd_op == 8'd2 && cmd_args == held && rd_count == rc,
        "R10 hold", rd_count - rc, 0);
    cmd_ready = 1'b1;
    take();
    wait_valid(200, got);
    chk(got && cmd_op == 8'd1 && cmd_args[31:0] == 32'd31, "R10 next after ready", cmd_op, 1);
    take();

    // R9 oversized cursor halts
    push(32'd19); push(32'd1); push(32'd0); push(32'd0); push(32'd4096); push(32'd64);
    push(32'd1); push(32'd1);
    publish();
    idle(60);
    chk(halted && !cmd_valid, "R9 reject", halted, 1);

    // R8 unknown opcode
    good_setup(prod);
    chk(!halted && cfg_ok, "R8 commit clears halt", halted, 0);
    push(32'd7);
    push(32'd1); push(32'd1); push(32'd1); push(32'd1); push(32'd1);
    publish();
    idle(20);
    rc = rd_count;
    idle(20);
    chk(halted && !cmd_valid && rd_count == rc, "R8 unknown halts", rd_count - rc, 0);
    good_setup(prod);
    push(32'h0000_0101);
    publish();
    idle(20);
    chk(halted, "R8 wide opcode", halted, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule